// File: doc/BRIEF.md
# Gated Reload Down-Counter with Toggle Output

This block is one channel of a timer group. A 16-bit counter steps down once for each pulse of a selected count source. After it has shown zero it reloads from a separate reload register on the next pulse, so a programmed value n divides the count source by n+1. On every reload the channel raises a one-cycle underflow flag. If enabled, it also flips a square-wave output.

The count sources come from a free-running prescaler on the system clock. A division select shared by the whole group picks which four divide ratios are on offer. A two-bit source field in the channel's mode byte picks one of those four. An optional gate input, brought in through a two-flop synchronizer, can hold the count whenever the input is not at a chosen level. This allows the width of an external pulse to be measured.

Software writes the timer value through one port. While the channel is stopped, the write lands in both the counter and the reload register. While the channel is running, it lands only in the reload register. The live count is always visible on an output.

The channel is built around a three-state machine:
- HALT: the start level is low, or it has just risen.
- RUN: counting, with a count that is not zero.
- ZERO: the count is zero and the channel waits for the reload pulse.

The transitions are:
- ARM: HALT to RUN or ZERO, on the first cycle with start high, depending on the count.
- EXPIRE: RUN to ZERO, on a step that brings the count to zero.
- RELOAD: ZERO to RUN, or ZERO to ZERO when the reload value is zero, on a step.
- STOP: any state to HALT, when start is low.

Top module: `gated_reload_timer`

## Requirements
- R1: After reset the count is 0, the toggle output is low and the underflow flag is low.
- R2: With reload value n and an unbroken count source, the count runs n, n-1, …, 0 and then n again, so one full period is n+1 count-source pulses.
- R3: A write while start is low places the written value in both the counter and the reload register on the next clock.
- R4: A write while start is high changes only the reload register. The running count is undisturbed, and the new value appears at the next reload.
- R5: While start is low the count holds its value and the toggle output is driven low.
- R6: Mode bit 2 set makes the toggle output flip on every reload. With bit 2 clear, the output stays low.
- R7: Mode bit 4 set enables gating. Mode bit 3 chooses the level that allows counting (1 = high, 0 = low). The gate input is seen through two synchronizing flops, and with bit 4 clear the gate input has no effect.
- R8: Mode bits 7:6 choose source k of four. The division select picks the set: 00 gives divide-by 1/16/64/512, 01 gives 2/16/64/4096, and 10 gives 1/64/512/4096. A divide-by-2^s source pulses in each cycle in which the low s bits of a free-running prescaler (cleared at reset, +1 per clock) are all ones.
- R9: Division select 11 is reserved and produces no count pulses, so the count holds.
- R10: The first clock with start high after a stop is an arming cycle in which no step is taken.
- R11: The underflow flag is high for exactly the cycle following each reload step and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_sel | input | 2 | Group-wide division select |
| start | input | 1 | Count-start level |
| wr_en | input | 1 | Timer value write strobe |
| wr_data | input | 16 | Timer value to write |
| mode_wr | input | 1 | Mode byte write strobe |
| mode_data | input | 8 | Mode byte (src[7:6], gate enable[4], gate level[3], toggle enable[2]) |
| gate_in | input | 1 | Asynchronous gate input |
| count | output | 16 | Live counter value |
| tout | output | 1 | Toggle output |
| underflow | output | 1 | One-cycle reload flag |

## Verification
The bench aims at the points where the write rules meet the run state. A design that always wrote the counter would bend a running period when a write arrives mid-count. A design that never wrote it while halted would start from a stale count. Reload with value 0 and back-to-back reloads on a divide-by-1 source check that the underflow flag and the toggle follow every step; a design that reloaded from the zero-detect instead of the following pulse would shorten every period by one. Gate patterns of uneven lengths, checked against the two-flop delay, the reserved division select and slow sources reached through the prescaler, catch off-by-one errors in the synchronizer and in the enable masks.

// File: rtl/grt_pkg.sv
package grt_pkg;

    typedef enum logic [1:0] {
        S_HALT = 2'd0,
        S_RUN  = 2'd1,
        S_ZERO = 2'd2
    } grt_state_t;

    // log2 of the divide ratio for a given group select and channel source
    function automatic int unsigned src_shift(input logic [1:0] dsel, input logic [1:0] src);
        int unsigned s;
        s = 0;
        unique case (dsel)
            2'b00: begin
                unique case (src)
                    2'd0: s = 0;
                    2'd1: s = 4;
                    2'd2: s = 6;
                    default: s = 9;
                endcase
            end
            2'b01: begin
                unique case (src)
                    2'd0: s = 1;
                    2'd1: s = 4;
                    2'd2: s = 6;
                    default: s = 12;
                endcase
            end
            default: begin
                unique case (src)
                    2'd0: s = 0;
                    2'd1: s = 6;
                    2'd2: s = 9;
                    default: s = 12;
                endcase
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/grt_prescaler.sv
module grt_prescaler #(
    parameter int PRESC_W = 12,
    parameter int NSRC    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      div_sel,
    output logic [NSRC-1:0] ticks
);
    import grt_pkg::*;

    logic [PRESC_W-1:0] pcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt <= '0;
        else        pcnt <= pcnt + 1'b1;
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic [PRESC_W-1:0] mask;
        always_comb begin
            mask = '0;
            for (int b = 0; b < PRESC_W; b++) begin
                if (b < int'(src_shift(div_sel, 2'(i)))) mask[b] = 1'b1;
            end
        end
        assign ticks[i] = (div_sel != 2'b11) && ((pcnt & mask) == mask);
    end

    // R9: reserved select never pulses
    assert_reserved_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (div_sel == 2'b11) |-> (ticks == '0));

endmodule

// File: rtl/grt_gate_sync.sv
module grt_gate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_in,
    input  logic gate_en,
    input  logic gate_lvl,
    output logic gate_ok
);
    logic [STAGES-1:0] sync;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= '0;
        else        sync <= {sync[STAGES-2:0], gate_in};
    end

    assign gate_ok = !gate_en || (sync[STAGES-1] == gate_lvl);

endmodule

// File: rtl/grt_core.sv
module grt_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             tick,
    input  logic             gate_ok,
    input  logic             pulse_en,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count,
    output logic             tout,
    output logic             underflow
);
    import grt_pkg::*;

    grt_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] rld_q, rld_d;
    logic             tout_d, uf_d;
    logic             step;

    assign step = start && tick && gate_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_HALT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (!start) begin
            state_d = S_HALT;                       // STOP
        end else begin
            unique case (state_q)
                S_HALT: state_d = (cnt_q == '0) ? S_ZERO : S_RUN;   // ARM
                S_RUN:  if (step && cnt_q == CNT_W'(1)) state_d = S_ZERO; // EXPIRE
                S_ZERO: if (step) state_d = (rld_q == '0) ? S_ZERO : S_RUN; // RELOAD
                default: state_d = S_HALT;
            endcase
        end
    end

    // datapath / outputs
    always_comb begin
        cnt_d  = cnt_q;
        rld_d  = rld_q;
        tout_d = tout;
        uf_d   = 1'b0;
        if (wr_en) begin
            rld_d = wr_data;
            if (!start) cnt_d = wr_data;
        end
        if (!start) begin
            tout_d = 1'b0;
        end else begin
            unique case (state_q)
                S_RUN:  if (step) cnt_d = cnt_q - 1'b1;
                S_ZERO: if (step) begin
                    cnt_d  = rld_q;
                    uf_d   = 1'b1;
                    tout_d = pulse_en ? !tout : tout;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            rld_q     <= '0;
            tout      <= 1'b0;
            underflow <= 1'b0;
        end else begin
            cnt_q     <= cnt_d;
            rld_q     <= rld_d;
            tout      <= tout_d;
            underflow <= uf_d;
        end
    end

    assign count = cnt_q;

    assert_halt_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !wr_en) |=> $stable(cnt_q));

    assert_tout_low_halt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!start) |=> !tout);

    assert_dec_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && step) |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_uf_from_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> ($past(cnt_q) == '0));

    assert_gate_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !gate_ok) |=> $stable(cnt_q));

    assert_arm_no_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HALT && start) |=> $stable(cnt_q));

endmodule

// File: rtl/gated_reload_timer.sv
module gated_reload_timer #(
    parameter int CNT_W   = 16,
    parameter int PRESC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       div_sel,
    input  logic             start,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             mode_wr,
    input  logic [7:0]       mode_data,
    input  logic             gate_in,
    output logic [CNT_W-1:0] count,
    output logic             tout,
    output logic             underflow
);
    localparam int NSRC = 4;

    logic [1:0]      src_q;
    logic            gate_en_q, gate_lvl_q, pulse_en_q;
    logic [NSRC-1:0] ticks;
    logic            tick, gate_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q      <= '0;
            gate_en_q  <= 1'b0;
            gate_lvl_q <= 1'b0;
            pulse_en_q <= 1'b0;
        end else if (mode_wr) begin
            src_q      <= mode_data[7:6];
            gate_en_q  <= mode_data[4];
            gate_lvl_q <= mode_data[3];
            pulse_en_q <= mode_data[2];
        end
    end

    grt_prescaler #(.PRESC_W(PRESC_W), .NSRC(NSRC)) u_presc (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .ticks(ticks)
    );

    assign tick = ticks[src_q];

    grt_gate_sync #(.STAGES(2)) u_gate (
        .clk(clk), .rst_n(rst_n), .gate_in(gate_in),
        .gate_en(gate_en_q), .gate_lvl(gate_lvl_q), .gate_ok(gate_ok)
    );

    grt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
        .gate_ok(gate_ok), .pulse_en(pulse_en_q), .wr_en(wr_en),
        .wr_data(wr_data), .count(count), .tout(tout), .underflow(underflow)
    );

    assert_tout_static_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_en_q && !tout) |=> !tout);

endmodule

// File: tb/gated_reload_timer_tb.sv
module gated_reload_timer_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  div_sel = 0;
    logic        start = 0;
    logic        wr_en = 0;
    logic [15:0] wr_data = 0;
    logic        mode_wr = 0;
    logic [7:0]  mode_data = 0;
    logic        gate_in = 0;
    logic [15:0] count;
    logic        tout, underflow;

    int checks = 0, fails = 0;
    string phase = "R1";
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gated_reload_timer u_dut (
        .clk(clk), .rst_n(rst_n), .div_sel(div_sel), .start(start),
        .wr_en(wr_en), .wr_data(wr_data), .mode_wr(mode_wr),
        .mode_data(mode_data), .gate_in(gate_in),
        .count(count), .tout(tout), .underflow(underflow)
    );

    // behavioural reference
    int m_cnt, m_rld, m_tout, m_uf, m_armed, m_p, m_g1, m_g2;
    int m_src, m_gen, m_glv, m_pen;

    function automatic int ratio_log(int d, int s);
        int t0[4] = '{0, 4, 6, 9};
        int t1[4] = '{1, 4, 6, 12};
        int t2[4] = '{0, 6, 9, 12};
        if (d == 0) return t0[s];
        if (d == 1) return t1[s];
        return t2[s];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_rld = 0; m_tout = 0; m_uf = 0; m_armed = 0;
            m_p = 0; m_g1 = 0; m_g2 = 0; m_src = 0; m_gen = 0; m_glv = 0; m_pen = 0;
        end else begin
            int pw, tk, gok, stp, old_rld;
            pw  = 1 << ratio_log(div_sel, m_src);
            tk  = (div_sel != 3) && ((m_p % pw) == pw - 1);
            gok = !m_gen || (m_g2 == m_glv);
            stp = start && tk && gok && m_armed;
            old_rld = m_rld;
            m_uf = 0;
            if (wr_en) begin
                m_rld = wr_data;
                if (!start) m_cnt = wr_data;
            end
            if (!start) begin
                m_tout = 0; m_armed = 0;
            end else if (!m_armed) begin
                m_armed = 1;
            end else if (stp) begin
                if (m_cnt == 0) begin
                    m_cnt = old_rld; m_uf = 1;
                    if (m_pen) m_tout = !m_tout;
                end else m_cnt = m_cnt - 1;
            end
            if (mode_wr) begin
                m_src = mode_data[7:6]; m_gen = mode_data[4];
                m_glv = mode_data[3];   m_pen = mode_data[2];
            end
            m_g2 = m_g1; m_g1 = gate_in;
            m_p = (m_p + 1) % 4096;
        end
    end

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(phase, count, m_cnt, "count");
            chk(phase, tout, m_tout, "tout");
            chk(phase, underflow, m_uf, "underflow");
        end
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(int v);
        @(negedge clk); wr_en = 1; wr_data = 16'(v);
        @(negedge clk); wr_en = 0;
    endtask

    task automatic setmode(logic [7:0] v);
        @(negedge clk); mode_wr = 1; mode_data = v;
        @(negedge clk); mode_wr = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        cyc(3);
        chk("R1", count, 0, "reset count");
        chk("R1", tout, 0, "reset tout");
        chk("R1", underflow, 0, "reset underflow");
        rst_n = 1;
        phase = "R6";  setmode(8'h04);              // f1, toggle enabled
        phase = "R3";  wr(5); cyc(1);
        chk("R3", count, 5, "halted write count");
        phase = "R10"; @(negedge clk); start = 1; cyc(2);
        phase = "R2";  cyc(20);
        phase = "R11"; cyc(6);
        phase = "R4";  wr(2); cyc(20);
        phase = "R5";  @(negedge clk); start = 0; cyc(5);
        chk("R5", tout, 0, "tout low when stopped");
        wr(0); cyc(2);
        phase = "R11"; @(negedge clk); start = 1; cyc(6);   // reload 0: back-to-back
        phase = "R3";  @(negedge clk); start = 0; wr(3); cyc(1);
        @(negedge clk); start = 1;
        phase = "R6";  setmode(8'h00); cyc(15);
        phase = "R7";  setmode(8'h1C);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); gate_in = ~gate_in; cyc(2 + (i * 3) % 7);
        end
        setmode(8'h14);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); gate_in = ~gate_in; cyc(3 + (i * 5) % 6);
        end
        setmode(8'h04);                               // gate off: gate_in ignored
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); gate_in = ~gate_in; cyc(3);
        end
        phase = "R8";  setmode(8'h44); cyc(200);
        @(negedge clk); div_sel = 2'b01; setmode(8'h04); cyc(60);
        @(negedge clk); div_sel = 2'b10; setmode(8'h84); wr(1); cyc(2200);
        phase = "R9";  @(negedge clk); div_sel = 2'b11; cyc(1);
        begin
            int held;
            held = count; cyc(600);
            chk("R9", count, held, "reserved select holds count");
        end
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

endmodule